// File: doc/BRIEF.md
# Bus Reply Packet Router

The router watches a byte stream that carries one finished packet at a time. Each byte is qualified by a valid strobe. A first marker opens a packet and a last marker closes it. When a packet closes, the block decides whether the packet is a device reply from the serial peripheral bus. If it is, the block pulls out the device address, the register number and a 16-bit register value, and forwards the value to one of a small set of client ports.

Which port receives the value depends on a fixed map from bus address to port. Two bus addresses share the keyboard port, and one address feeds the mouse port. A client takes deliveries only while its subscriber-enable input is high. Malformed device replies produce a one-cycle unrecognized strobe. Replies from the controller itself, truncated packets and replies to unmapped addresses are discarded with no indication.

All decisions are taken on the closing byte. Results appear one clock later.

Top module: `reply_router`

## Requirements
- R1: After reset, every port valid output, the unrecognized strobe, the value output and the poll flag are 0.
- R2: A packet whose byte 0 is not 0x00 produces no port valid pulse and no unrecognized strobe.
- R3: A packet of only one byte produces no port valid pulse and no unrecognized strobe.
- R4: A packet with byte 0 equal to 0x00 and a total length of 2 or more bytes, other than exactly 5, raises the unrecognized strobe for one cycle. That cycle is the cycle after the last byte is accepted.
- R5: A 5-byte packet with byte 0 equal to 0x00 and bits [1:0] of byte 2 not zero raises the unrecognized strobe and delivers nothing.
- R6: An accepted packet drives port_value to {byte 3, byte 4}, with byte 3 in the high half. It pulses the chosen port's valid output for exactly one cycle, the cycle after the last byte.
- R7: The bus address is bits [7:4] of byte 2. Addresses 2 and 8 map to port 0 (keyboard), and address 9 maps to port 1 (mouse).
- R8: An accepted packet whose address has no mapping produces no port valid pulse and no unrecognized strobe.
- R9: When the target port's sub_en bit is low at the last byte, nothing is delivered, and port_value and poll_flag keep their previous values.
- R10: poll_flag takes bit 6 of byte 1 on each delivery and holds it until the next delivery.
- R11: Cycles with in_valid low inside a packet are skipped. Bytes that arrive outside a packet without a first marker are ignored.
- R12: In any cycle, at most one port valid output or the unrecognized strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Byte qualifier |
| in_data | input | 8 | Packet byte |
| in_first | input | 1 | Byte opens a packet |
| in_last | input | 1 | Byte closes a packet |
| sub_en | input | 2 | Per-port subscriber present |
| port_valid | output | 2 | One-cycle delivery strobe per port |
| port_value | output | 16 | Last delivered register value |
| poll_flag | output | 1 | Autopoll bit of the last delivery |
| unrec_pulse | output | 1 | One-cycle strobe for a malformed device reply |

## Verification
The assertions assume the receive side never sends packets closer together than one closing byte per cycle. They also assume that sub_en is stable on the closing byte. The one-cycle pulse checks rely on the shortest packet that raises a strobe being at least two bytes long, so strobes can never fall on adjacent cycles. The stimulus drives bytes and sub_en only on falling edges. Every packet it sends has at least two bytes whenever a strobe is expected. It also includes back-to-back packets, gaps inside packets and stray bytes with no first marker, so that the skipping rules are exercised within those assumptions.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int NPORT     = 2;
  localparam int PORT_W    = 1;
  localparam int MAX_CNT   = 15;
  localparam int CNT_W     = $clog2(MAX_CNT + 1);
  localparam int LEN_W     = CNT_W + 1;
  localparam int GOOD_LEN  = 5;
  localparam logic [7:0] TYPE_BUS = 8'h00;
  localparam int PORT_KBD  = 0;
  localparam int PORT_MOUSE = 1;

  typedef struct packed {
    logic              hit;
    logic [PORT_W-1:0] idx;
  } route_t;

  function automatic route_t addr_route(input logic [3:0] addr);
    route_t r;
    r.hit = 1'b0;
    r.idx = '0;
    case (addr)
      4'd2, 4'd8: begin r.hit = 1'b1; r.idx = PORT_W'(PORT_KBD);   end
      4'd9:       begin r.hit = 1'b1; r.idx = PORT_W'(PORT_MOUSE); end
      default:    ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rr_parse.sv
module rr_parse
  import rr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_first,
  input  logic             in_last,
  output logic             done,
  output logic [LEN_W-1:0] len,
  output logic [7:0]       typ_v,
  output logic             ap_v,
  output logic [3:0]       addr_v,
  output logic [1:0]       reg_v,
  output logic [7:0]       hi_v,
  output logic [7:0]       lo_v
);
  logic             in_pkt_q, in_pkt_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, idx;
  logic [7:0]       typ_q;
  logic             ap_q;
  logic [3:0]       addr_q;
  logic [1:0]       reg_q;
  logic [7:0]       hi_q;
  logic             take;

  assign take = in_valid && (in_first || in_pkt_q);
  assign idx  = in_first ? '0 : cnt_q;
  assign done = take && in_last;
  assign len  = {1'b0, idx} + LEN_W'(1);

  always_comb begin
    in_pkt_n = in_pkt_q;
    cnt_n    = cnt_q;
    if (take) begin
      in_pkt_n = !in_last;
      cnt_n    = (idx == CNT_W'(MAX_CNT)) ? idx : idx + CNT_W'(1);
    end
  end

  always_comb begin
    typ_v  = (idx == CNT_W'(0)) ? in_data    : typ_q;
    ap_v   = (idx == CNT_W'(1)) ? in_data[6] : ap_q;
    addr_v = (idx == CNT_W'(2)) ? in_data[7:4] : addr_q;
    reg_v  = (idx == CNT_W'(2)) ? in_data[1:0] : reg_q;
    hi_v   = (idx == CNT_W'(3)) ? in_data    : hi_q;
    lo_v   = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      cnt_q    <= '0;
      typ_q    <= '0;
      ap_q     <= 1'b0;
      addr_q   <= '0;
      reg_q    <= '0;
      hi_q     <= '0;
    end else begin
      in_pkt_q <= in_pkt_n;
      cnt_q    <= cnt_n;
      if (take && idx == CNT_W'(0)) typ_q <= in_data;
      if (take && idx == CNT_W'(1)) ap_q  <= in_data[6];
      if (take && idx == CNT_W'(2)) begin
        addr_q <= in_data[7:4];
        reg_q  <= in_data[1:0];
      end
      if (take && idx == CNT_W'(3)) hi_q <= in_data;
    end
  end
endmodule

// File: rtl/rr_classify.sv
module rr_classify
  import rr_pkg::*;
(
  input  logic             done,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       typ_v,
  input  logic [1:0]       reg_v,
  output logic             accept,
  output logic             reject
);
  logic quiet_drop, well_formed;

  always_comb begin
    quiet_drop  = (typ_v != TYPE_BUS) || (len < LEN_W'(2));
    well_formed = (len == LEN_W'(GOOD_LEN)) && (reg_v == 2'b00);
    accept      = done && !quiet_drop && well_formed;
    reject      = done && !quiet_drop && !well_formed;
  end
endmodule

// File: rtl/rr_route.sv
module rr_route
  import rr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             reject,
  input  logic [3:0]       addr_v,
  input  logic             ap_v,
  input  logic [15:0]      val_v,
  input  logic [NPORT-1:0] sub_en,
  output logic [NPORT-1:0] port_valid,
  output logic [15:0]      port_value,
  output logic             poll_flag,
  output logic             unrec_pulse
);
  route_t           rt;
  logic [NPORT-1:0] pv_n;
  logic             load;
  logic [15:0]      val_n;
  logic             ap_n;

  assign rt = addr_route(addr_v);

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign pv_n[g] = accept && rt.hit && (rt.idx == PORT_W'(g)) && sub_en[g];
  end

  always_comb begin
    load  = |pv_n;
    val_n = load ? val_v : port_value;
    ap_n  = load ? ap_v  : poll_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_valid  <= '0;
      port_value  <= '0;
      poll_flag   <= 1'b0;
      unrec_pulse <= 1'b0;
    end else begin
      port_valid  <= pv_n;
      unrec_pulse <= reject;
      port_value  <= val_n;
      poll_flag   <= ap_n;
    end
  end
endmodule

// File: rtl/reply_router.sv
module reply_router
  import rr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_first,
  input  logic             in_last,
  input  logic [NPORT-1:0] sub_en,
  output logic [NPORT-1:0] port_valid,
  output logic [15:0]      port_value,
  output logic             poll_flag,
  output logic             unrec_pulse
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic             done, ap_v, accept, reject;
  logic [LEN_W-1:0] len;
  logic [7:0]       typ_v, hi_v, lo_v;
  logic [3:0]       addr_v;
  logic [1:0]       reg_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  rr_parse u_parse (
    .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .done(done), .len(len),
    .typ_v(typ_v), .ap_v(ap_v), .addr_v(addr_v), .reg_v(reg_v),
    .hi_v(hi_v), .lo_v(lo_v)
  );

  rr_classify u_class (
    .done(done), .len(len), .typ_v(typ_v), .reg_v(reg_v),
    .accept(accept), .reject(reject)
  );

  rr_route u_route (
    .clk(clk), .rst_n(rst_core_n), .accept(accept), .reject(reject),
    .addr_v(addr_v), .ap_v(ap_v), .val_v({hi_v, lo_v}), .sub_en(sub_en),
    .port_valid(port_valid), .port_value(port_value), .poll_flag(poll_flag),
    .unrec_pulse(unrec_pulse)
  );
endmodule

// File: rtl/rr_chk.sv
module rr_chk
  import rr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_last,
  input logic [NPORT-1:0] sub_en,
  input logic [NPORT-1:0] port_valid,
  input logic [15:0]      port_value,
  input logic             poll_flag,
  input logic             unrec_pulse
);
  // R12
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({port_valid, unrec_pulse}));
  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|port_valid) |=> !(|port_valid));
  // R4
  unrec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unrec_pulse |=> !unrec_pulse);
  // R6
  valid_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|port_valid) |-> $past(in_valid && in_last));
  // R4
  unrec_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unrec_pulse |-> $past(in_valid && in_last));
  // R9
  value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|port_valid) |-> ($stable(port_value) && $stable(poll_flag)));
  for (genvar g = 0; g < NPORT; g++) begin : g_sub
    // R9
    sub_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_valid[g] |-> $past(sub_en[g]));
  end
endmodule

bind reply_router rr_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid), .in_last(in_last),
  .sub_en(sub_en), .port_valid(port_valid), .port_value(port_value),
  .poll_flag(poll_flag), .unrec_pulse(unrec_pulse)
);

// File: tb/sim_reply_router.sv
`timescale 1ns/1ps
module sim_reply_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [1:0] sub_en = 2'b11;
  logic [1:0] port_valid;
  logic [15:0] port_value;
  logic       poll_flag, unrec_pulse;

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";

  reply_router u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .sub_en(sub_en),
    .port_valid(port_valid), .port_value(port_value), .poll_flag(poll_flag),
    .unrec_pulse(unrec_pulse)
  );

  always #2 clk = ~clk;

  // behavioural reference
  byte unsigned pq[$];
  bit          inpk = 0;
  logic [1:0]  e_pv = 0;
  logic [15:0] e_val = 0;
  logic        e_ap = 0, e_un = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pq.delete(); inpk = 0; e_pv = 0; e_val = 0; e_ap = 0; e_un = 0;
    end else begin
      e_pv = 0; e_un = 0;
      if (in_valid && (in_first || inpk)) begin
        if (in_first) pq.delete();
        pq.push_back(in_data);
        inpk = !in_last;
        if (in_last && pq[0] == 0 && pq.size() >= 2) begin
          if (pq.size() != 5 || pq[2][1:0] != 0) e_un = 1;
          else begin
            int p;
            case (pq[2][7:4])
              2, 8: p = 0;
              9:    p = 1;
              default: p = -1;
            endcase
            if (p >= 0 && sub_en[p]) begin
              e_pv[p] = 1'b1;
              e_val = {pq[3], pq[4]};
              e_ap = pq[1][6];
            end
          end
        end
      end
    end
  end

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && cycles > 3) begin
    chk("port_valid", {14'd0, port_valid}, {14'd0, e_pv});
    chk("port_value", port_value, e_val);
    chk("poll_flag", {15'd0, poll_flag}, {15'd0, e_ap});
    chk("unrec_pulse", {15'd0, unrec_pulse}, {15'd0, e_un});
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic send(input byte unsigned b[$], input int gap);
    for (int i = 0; i < b.size(); i++) begin
      in_valid = 1; in_data = b[i];
      in_first = (i == 0); in_last = (i == b.size() - 1);
      @(negedge clk);
      in_valid = 0; in_first = 0; in_last = 0;
      for (int k = 0; k < gap; k++) begin
        in_data = 8'hFF;
        @(negedge clk);
      end
    end
    in_valid = 0; in_first = 0; in_last = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cur_req = "R1";
    chk("reset outputs R1", {port_valid, poll_flag, unrec_pulse, 12'd0}, 16'd0);
    chk("reset value R1", port_value, 16'd0);
    cur_req = "R7"; send('{8'h00, 8'h00, 8'h20, 8'h12, 8'h34}, 0);
    cur_req = "R10"; send('{8'h00, 8'h40, 8'h80, 8'hAB, 8'hCD}, 0);
    cur_req = "R11"; send('{8'h00, 8'h00, 8'h90, 8'h55, 8'hAA}, 2);
    cur_req = "R2"; send('{8'h01, 8'h01, 8'h01}, 0);
    send('{8'h02, 8'h00, 8'h20, 8'h99, 8'h99}, 0);
    cur_req = "R3"; send('{8'h00}, 0);
    cur_req = "R4"; send('{8'h00, 8'h00}, 0);
    send('{8'h00, 8'h00, 8'h20, 8'h11}, 0);
    send('{8'h00, 8'h00, 8'h20, 8'h11, 8'h22, 8'h33}, 0);
    cur_req = "R5"; send('{8'h00, 8'h00, 8'h21, 8'h77, 8'h77}, 0);
    send('{8'h00, 8'h00, 8'h93, 8'h77, 8'h77}, 0);
    cur_req = "R8"; send('{8'h00, 8'h00, 8'h50, 8'h66, 8'h66}, 0);
    cur_req = "R9"; sub_en = 2'b10;
    send('{8'h00, 8'h40, 8'h20, 8'hDE, 8'hAD}, 0);
    sub_en = 2'b01;
    send('{8'h00, 8'h00, 8'h90, 8'hBE, 8'hEF}, 0);
    sub_en = 2'b11;
    cur_req = "R11";
    in_valid = 1; in_data = 8'h00; @(negedge clk);
    in_last = 1; @(negedge clk);
    in_valid = 0; in_last = 0; @(negedge clk);
    send('{8'h00, 8'h00, 8'h80, 8'h0F, 8'hF0}, 0);
    cur_req = "R6";
    for (int i = 0; i < 4; i++) begin
      byte unsigned a = (i % 2) ? 8'h90 : 8'h20;
      in_valid = 1;
      for (int j = 0; j < 5; j++) begin
        in_first = (j == 0); in_last = (j == 4);
        case (j)
          0: in_data = 8'h00;
          1: in_data = 8'h40 & {8{i[0]}};
          2: in_data = a;
          3: in_data = 8'(i * 16 + 1);
          default: in_data = 8'(255 - i);
        endcase
        @(negedge clk);
      end
    end
    in_valid = 0; in_first = 0; in_last = 0;
    cur_req = "R12";
    send('{8'h00, 8'h00, 8'h90, 8'h42, 8'h24}, 0);
    repeat (4) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule